// File: doc/BRIEF.md
# Per-Block Lock and Protect Controller

This block decides, cycle by cycle, whether a host access to a block-erasable flash array may go ahead. The array is split into equal 64 KB blocks, each erasable or programmable on its own. The bus front end presents a byte address, an access type and a valid strobe. The controller answers in the same cycle with either a grant or a deny. When a read is refused, the value returned to the host is forced to all ones.

Two sources decide each outcome. The first is a small lock register per block, which the host can write and read back. It holds a read-lock bit, a write-lock bit and a sticky lock-down bit. Once lock-down is set, the register is frozen until reset. The second source is a pair of hardware protection pins. One pin shields only the highest block. The other shields every other block. Both pins affect only writes and erases, never reads.

Top module: `blk_guard`

## Requirements
- R1: After reset, every lock register reads back 3'b001, meaning write-lock set and lock-down and read-lock clear. Bit 0 is write-lock, bit 1 is lock-down, bit 2 is read-lock.
- R2: A configuration write to a block whose lock-down bit is clear replaces all three bits of that block's register. The new value reads back from the cycle after the write.
- R3: While a block's lock-down bit is set, configuration writes to that block leave its register unchanged, with no error indication.
- R4: A set lock-down bit stays set until reset. Writing 0 to it has no effect, and reset clears it back to the R1 value.
- R5: A write/erase access (acc_wr = 1) to a block whose write-lock bit is set is denied. With write-lock clear and no pin protection, it is granted.
- R6: While top_prot is high, write/erase accesses to the highest block (index NBLK-1) are denied. Writes to other blocks are not affected by this pin.
- R7: While rest_prot is high, write/erase accesses to every block except the highest are denied. The highest block is not affected by this pin.
- R8: A read access (acc_wr = 0) is denied exactly when the block's read-lock bit is set. A denied read drives rdata to 8'hFF; otherwise rdata equals arr_rdata. The protection pins never deny a read.
- R9: grant and deny are never high together, both are low while acc_vld is low, and exactly one is high while acc_vld is high.
- R10: The target block index is acc_addr[18:16]. Address 19'h0FFFF falls in block 0, 19'h10000 in block 1, and 19'h7FFFF in block 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | Access request valid |
| acc_wr | input | 1 | 1 = write/erase, 0 = read |
| acc_addr | input | 19 | Byte address of the access |
| arr_rdata | input | 8 | Read data from the array |
| top_prot | input | 1 | Protects the highest block against write/erase |
| rest_prot | input | 1 | Protects all other blocks against write/erase |
| cfg_we | input | 1 | Lock register write strobe |
| cfg_blk | input | 3 | Lock register index for write and read-back |
| cfg_wdata | input | 3 | Lock register write value |
| cfg_rdata | output | 3 | Lock register read-back of block cfg_blk |
| grant | output | 1 | Access allowed |
| deny | output | 1 | Access refused |
| rdata | output | 8 | Read data to the host, 8'hFF on a refused read |

## Verification
A corrupted lock register shows at the ports in the very next cycle. It appears through cfg_rdata read-back, and as a flipped grant/deny or an 8'hFF read on the next access to that block. A lock-down bit that fails to stick shows up as a register that changes after a later write. A decode fault in the block index or the pin region shows up as a deny on the wrong side of a 64 KB boundary. The bench therefore probes both sides of each boundary and both sides of the top block.

// File: rtl/blk_guard.sv
module blk_guard #(
  parameter int NBLK      = 8,
  parameter int ADDR_W    = 19,
  parameter int BLK_SHIFT = 16,
  parameter int DATA_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_vld,
  input  logic                     acc_wr,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [DATA_W-1:0]        arr_rdata,
  input  logic                     top_prot,
  input  logic                     rest_prot,
  input  logic                     cfg_we,
  input  logic [$clog2(NBLK)-1:0]  cfg_blk,
  input  logic [2:0]               cfg_wdata,
  output logic [2:0]               cfg_rdata,
  output logic                     grant,
  output logic                     deny,
  output logic [DATA_W-1:0]        rdata
);
  localparam int IDX_W = $clog2(NBLK);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(NBLK - 1);
  localparam int B_WL = 0;
  localparam int B_LD = 1;
  localparam int B_RL = 2;
  localparam logic [2:0] RST_VAL = 3'b001;

  logic [2:0] lock_q [NBLK];

  wire [IDX_W-1:0] idx = acc_addr[BLK_SHIFT +: IDX_W];
  wire unused_low = ^acc_addr[BLK_SHIFT-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) lock_q[i] <= RST_VAL;
    end else if (cfg_we && !lock_q[cfg_blk][B_LD]) begin
      lock_q[cfg_blk] <= cfg_wdata;
    end
  end

  wire pin_hold = (idx == TOP) ? top_prot : rest_prot;
  wire wr_block = lock_q[idx][B_WL] | pin_hold;
  wire rd_block = lock_q[idx][B_RL];
  wire blocked  = acc_wr ? wr_block : rd_block;

  assign grant     = acc_vld & ~blocked;
  assign deny      = acc_vld &  blocked;
  assign rdata     = (acc_vld & ~acc_wr & rd_block) ? '1 : arr_rdata;
  assign cfg_rdata = lock_q[cfg_blk];

  for (genvar g = 0; g < NBLK; g++) begin : g_chk
    p_ld_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[g][B_LD] |=> lock_q[g][B_LD]);
    p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[g][B_LD] |=> $stable(lock_q[g]));
  end

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |-> (!grant && !deny));
  p_top_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_wr && top_prot && idx == TOP) |-> deny);
  p_rest_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_wr && rest_prot && idx != TOP) |-> deny);
  p_rd_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc_wr && deny) |-> (rdata == '1));
  p_upd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_rdata[B_LD]) |=> (lock_q[$past(cfg_blk)] == $past(cfg_wdata)));
endmodule

// File: tb/blk_guard_tb_top.sv
module blk_guard_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic acc_vld = 0, acc_wr = 0;
  logic [18:0] acc_addr = '0;
  logic [7:0] arr_rdata = 8'h00;
  logic top_prot = 0, rest_prot = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_blk = '0, cfg_wdata = '0;
  logic [2:0] cfg_rdata;
  logic grant, deny;
  logic [7:0] rdata;

  always #5 clk = ~clk;

  blk_guard dut_i (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .arr_rdata(arr_rdata), .top_prot(top_prot),
    .rest_prot(rest_prot), .cfg_we(cfg_we), .cfg_blk(cfg_blk),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .grant(grant),
    .deny(deny), .rdata(rdata));

  typedef struct packed {
    logic       is_cfg;
    logic [3:0] req;
    logic       g;
    logic       d;
    logic [7:0] rd;
    logic [2:0] cfg;
  } item_t;

  item_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0;
  logic [2:0] mdl [8];

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      checks++;
      if (it.is_cfg) begin
        if (cfg_rdata !== it.cfg) begin
          fails++;
          $display("FAIL R%0d: cfg_rdata=%b expected %b", it.req, cfg_rdata, it.cfg);
        end
      end else if (grant !== it.g || deny !== it.d || rdata !== it.rd) begin
        fails++;
        $display("FAIL R%0d: grant=%b deny=%b rdata=%h expected %b %b %h",
                 it.req, grant, deny, rdata, it.g, it.d, it.rd);
      end
    end
  end

  task automatic mdl_reset();
    for (int i = 0; i < 8; i++) mdl[i] = 3'b001;
  endtask

  task automatic cfg_read(input logic [2:0] b, input int r);
    cfg_blk = b;
    exp_q.push_back('{is_cfg: 1, req: 4'(r), g: 0, d: 0, rd: 0, cfg: mdl[b]});
    @(posedge clk); #1;
  endtask

  task automatic cfg_write(input logic [2:0] b, input logic [2:0] v);
    cfg_we = 1; cfg_blk = b; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 0;
    if (!mdl[b][1]) mdl[b] = v;
  endtask

  task automatic access(input logic vld, input logic wr, input logic [18:0] a,
                        input logic [7:0] arr, input int r);
    logic [2:0] b;
    logic blk, pin;
    item_t it;
    b = a[18:16];
    pin = (b == 3'd7) ? top_prot : rest_prot;
    blk = wr ? (mdl[b][0] | pin) : mdl[b][2];
    acc_vld = vld; acc_wr = wr; acc_addr = a; arr_rdata = arr;
    it = '{is_cfg: 0, req: 4'(r), g: vld & ~blk, d: vld & blk,
           rd: (vld & ~wr & mdl[b][2]) ? 8'hFF : arr, cfg: 0};
    exp_q.push_back(it);
    @(posedge clk); #1;
    acc_vld = 0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    mdl_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int i = 0; i < 8; i++) cfg_read(3'(i), 1);            // R1
    access(1, 0, 19'h0FFFF, 8'h5A, 10);                        // R10 block 0
    access(1, 0, 19'h10000, 8'hA5, 10);                        // R10 block 1
    access(1, 0, 19'h7FFFF, 8'h3C, 8);                         // R8 plain read
    access(1, 1, 19'h30010, 8'h00, 5);                         // R5 write-locked
    cfg_write(3'd3, 3'b000);
    cfg_read(3'd3, 2);                                         // R2
    access(1, 1, 19'h30010, 8'h00, 5);                         // R5 granted
    cfg_write(3'd2, 3'b100);
    cfg_read(3'd2, 2);                                         // R2
    access(1, 0, 19'h2ABCD, 8'h11, 8);                         // R8 denied -> FF
    access(1, 1, 19'h2ABCD, 8'h11, 5);                         // R5 write ok
    access(1, 0, 19'h1FFFF, 8'h22, 10);                        // R10 block 1 not locked
    cfg_write(3'd7, 3'b000);
    top_prot = 1;
    access(1, 1, 19'h70000, 8'h00, 6);                         // R6 top denied
    access(1, 1, 19'h3FFFF, 8'h00, 6);                         // R6 others free
    access(1, 0, 19'h70000, 8'h44, 6);                         // R6 reads free
    top_prot = 0; rest_prot = 1;
    access(1, 1, 19'h70000, 8'h00, 7);                         // R7 top free
    access(1, 1, 19'h30000, 8'h00, 7);                         // R7 other denied
    access(1, 0, 19'h30000, 8'h55, 7);                         // R7 read ok
    rest_prot = 0;
    cfg_write(3'd5, 3'b110);
    cfg_read(3'd5, 2);                                         // R2
    cfg_write(3'd5, 3'b000);
    cfg_read(3'd5, 3);                                         // R3 ignored
    cfg_write(3'd5, 3'b101);
    cfg_read(3'd5, 4);                                         // R4 still locked down
    access(1, 0, 19'h50000, 8'h66, 3);                         // R3 read lock kept
    access(1, 1, 19'h50000, 8'h00, 3);                         // R3 write lock stays 0
    access(0, 1, 19'h30000, 8'h77, 9);                         // R9 idle
    access(0, 0, 19'h20000, 8'h88, 9);                         // R9 idle
    rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    mdl_reset();
    cfg_read(3'd5, 4);                                         // R4 reset clears
    cfg_read(3'd3, 1);                                         // R1
    access(1, 1, 19'h50000, 8'h00, 5);                         // R5 relocked
    @(posedge clk); #1;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule